// File: doc/BRIEF.md
# Multi-Register Vector Transfer Sequencer

This block steps a vector load or store through a list of 64-bit registers. A single start command names the first register, the list length, whether consecutive list entries are one or two register numbers apart, an alignment hint, an endianness flag, the transfer kind, and the number of elements per structure. The sequencer then produces one transfer beat per accepted cycle. Each beat carries up to two register numbers, because the datapath moves at most two 64-bit registers at a time. Memory, address generation, element shuffling and the register file are outside the block. They see only the beat port, which is paced by a ready input.

The total length of a sequence depends on the transfer kind. A plain one-register transfer always costs two cycles. A list transfer costs one cycle per register pair plus one fixed setup cycle. A structure transfer also costs one cycle per pair, but it drops the setup cycle when the hint promises 128-bit or wider alignment. For loads, the block reports the pipeline stage at which the loaded data becomes usable. The block checks each command when it arrives and flags any command it cannot run.

Top module: `xferSeq`

## Requirements
- R1: After reset, busy, done, cmdError and beatValid are all 0.
- R2: A list transfer (cmdMode=1) of N registers, with N in 1..16, keeps busy high for exactly floor(N/2)+(N mod 2)+1 cycles when beatReady stays high. Busy rises in the cycle after the start, and the first of these cycles is a setup cycle with no beat.
- R3: Beat k carries slot0Reg = base+2*k*s and slot1Reg = base+(2*k+1)*s, where s is the stride. slot0Valid is 1 on every beat. slot1Valid is 0 only on the final beat of an odd-length list.
- R4: The stride s is 2 when cmdDouble=1 and 1 otherwise.
- R5: A single-register transfer (cmdMode=0) always takes 2 cycles: one setup cycle and one beat with only slot 0 valid. It ignores cmdCount, cmdAlign and cmdDouble.
- R6: A structure transfer (cmdMode=2) of N registers, with N in 1..4, takes ceil(N/2) beats. It adds one leading setup cycle only when cmdAlign is 0 (none) or 1 (64-bit). Codes 2 (128-bit) and 3 (256-bit) remove the setup cycle.
- R7: During load beats, resultStage is 0 (stage N1) when cmdBigEnd=0 and 1 (stage N2) when cmdBigEnd=1, for modes 0 and 1 and for structures with cmdElems=1. Structures with cmdElems of 2..4 always report 1. On store beats resultStage is 0.
- R8: The block rejects a start if any of these holds: the list length is 0; the length exceeds 16 in mode 1 or 4 in mode 2; cmdElems lies outside 1..4 in mode 2; the last register number exceeds 31; or cmdMode=3. A rejected start pulses cmdError for one cycle, in the cycle after the start, and produces no busy and no beat.
- R9: A start that arrives while busy is high is ignored and does not change the running sequence.
- R10: done pulses for exactly one cycle per sequence, on the cycle in which the final beat is accepted. busy is low in the next cycle.
- R11: While beatReady is low, a presented beat holds its register numbers. Each stalled cycle lengthens the sequence by one cycle.
- R12: The command fields are captured at the start. Changes to the inputs during a sequence do not affect the beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Start strobe for a new command |
| cmdMode | input | 2 | 0 single register, 1 register list, 2 structure, 3 reserved |
| cmdIsLoad | input | 1 | 1 for load, 0 for store |
| cmdBase | input | 5 | First register number |
| cmdCount | input | 5 | Number of registers in the list |
| cmdDouble | input | 1 | Stride of two between list entries |
| cmdAlign | input | 2 | Alignment hint: 0 none, 1 64-bit, 2 128-bit, 3 256-bit |
| cmdElems | input | 3 | Elements per structure, 1..4 |
| cmdBigEnd | input | 1 | Big-endian data layout |
| beatReady | input | 1 | Memory side accepts the current beat |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | Final beat accepted this cycle |
| cmdError | output | 1 | Last start was rejected |
| beatValid | output | 1 | A beat is presented |
| beatIsLoad | output | 1 | Direction of the presented beat |
| slot0Reg | output | 5 | First register number of the beat |
| slot0Valid | output | 1 | Slot 0 carries a register |
| slot1Reg | output | 5 | Second register number of the beat |
| slot1Valid | output | 1 | Slot 1 carries a register |
| resultStage | output | 1 | Load data usable at 0 = N1, 1 = N2 |

## Verification
List transfers are swept over every length from 0 to 20, several base registers and both strides. This separates the even and odd pair counts, the setup cycle, the rejection of zero, over-long and out-of-range lists, and the stride choice. Structure transfers are swept over all alignment codes and element counts, which shows whether alignment removes the setup cycle and whether the element count forces stage N2 regardless of endianness. Single-register runs vary every field the mode must ignore. Further runs stall the ready input periodically and issue a second start during a sequence, which shows that beats are held and that starts arriving while busy are dropped.

// File: rtl/xferSeqPkg.sv
package xferSeqPkg;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'd0,
    MODE_MULTI  = 2'd1,
    MODE_STRUCT = 2'd2,
    MODE_RSVD   = 2'd3
  } xferModeT;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_XFER  = 2'd2
  } seqStateT;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadCmd;   // capture the command fields, clear beat index
    logic advance;   // current beat accepted, move to next pair
  } seqStrobeT;

endpackage

// File: rtl/xferSeqCtrl.sv
module xferSeqCtrl
  import xferSeqPkg::*;
#(
  parameter int REG_IDX_W  = 5,
  parameter int CNT_W      = 5,
  parameter int ELEM_W     = 3,
  parameter int NUM_REGS   = 32,
  parameter int MAX_MULTI  = 16,
  parameter int MAX_STRUCT = 4,
  parameter int MAX_ELEMS  = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startValid,
  input  logic [1:0]           cmdMode,
  input  logic [REG_IDX_W-1:0] cmdBase,
  input  logic [CNT_W-1:0]     cmdCount,
  input  logic                 cmdDouble,
  input  logic [1:0]           cmdAlign,
  input  logic [ELEM_W-1:0]    cmdElems,
  input  logic                 beatReady,
  input  logic                 lastBeat,
  output seqStrobeT            strobe,
  output logic [CNT_W-1:0]     listLen,
  output logic                 busy,
  output logic                 done,
  output logic                 beatValid,
  output logic                 cmdError
);

  localparam int SPAN_W = REG_IDX_W + CNT_W + 2;

  seqStateT stateQ;
  logic errQ;
  xferModeT mode;
  logic [SPAN_W-1:0] baseW, strideW, countW, lastIdx;
  logic countBad, rangeBad, cmdBad, needSetup, accept;

  always_comb begin
    mode    = xferModeT'(cmdMode);
    listLen = (mode == MODE_SINGLE) ? CNT_W'(1) : cmdCount;
    baseW   = SPAN_W'(cmdBase);
    strideW = cmdDouble ? SPAN_W'(2) : SPAN_W'(1);
    countW  = SPAN_W'(listLen);
    lastIdx = baseW + strideW * (countW - SPAN_W'(1));
    rangeBad = (listLen != '0) && (lastIdx > SPAN_W'(NUM_REGS - 1));
    unique case (mode)
      MODE_SINGLE: countBad = 1'b0;
      MODE_MULTI:  countBad = (listLen == '0) || (listLen > CNT_W'(MAX_MULTI));
      MODE_STRUCT: countBad = (listLen == '0) || (listLen > CNT_W'(MAX_STRUCT)) ||
                              (cmdElems == '0) || (cmdElems > ELEM_W'(MAX_ELEMS));
      default:     countBad = 1'b1;
    endcase
    cmdBad    = countBad || rangeBad;
    // Structure transfers with 128-bit or wider alignment skip the setup cycle
    needSetup = !((mode == MODE_STRUCT) && cmdAlign[1]);
    accept    = startValid && (stateQ == ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      errQ   <= 1'b0;
    end else begin
      errQ <= accept && cmdBad;
      unique case (stateQ)
        ST_IDLE: begin
          if (accept && !cmdBad) stateQ <= needSetup ? ST_SETUP : ST_XFER;
        end
        ST_SETUP: stateQ <= ST_XFER;
        ST_XFER: begin
          if (beatReady && lastBeat) stateQ <= ST_IDLE;
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.loadCmd = accept && !cmdBad;
    strobe.advance = (stateQ == ST_XFER) && beatReady;
    beatValid      = (stateQ == ST_XFER);
    done           = beatValid && beatReady && lastBeat;
    busy           = (stateQ != ST_IDLE);
    cmdError       = errQ;
  end

endmodule

// File: rtl/xferSeqPath.sv
module xferSeqPath
  import xferSeqPkg::*;
#(
  parameter int REG_IDX_W = 5,
  parameter int CNT_W     = 5,
  parameter int ELEM_W    = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  seqStrobeT            strobe,
  input  logic [1:0]           cmdMode,
  input  logic                 cmdIsLoad,
  input  logic [REG_IDX_W-1:0] cmdBase,
  input  logic [CNT_W-1:0]     listLen,
  input  logic                 cmdDouble,
  input  logic [ELEM_W-1:0]    cmdElems,
  input  logic                 cmdBigEnd,
  output logic [REG_IDX_W-1:0] slot0Reg,
  output logic [REG_IDX_W-1:0] slot1Reg,
  output logic                 slot0Live,
  output logic                 slot1Live,
  output logic                 lastBeat,
  output logic                 beatIsLoad,
  output logic                 resultStage
);

  localparam int POS_W = CNT_W + 1;
  localparam int SUM_W = REG_IDX_W + POS_W + 2;

  logic [REG_IDX_W-1:0] baseQ;
  logic [CNT_W-1:0]     lenQ, beatQ;
  logic                 doubleQ, loadQ, stageQ;
  logic [POS_W-1:0]     pairPos, lenW;
  logic [SUM_W-1:0]     off0, sum0, sum1;
  logic                 stageNext;

  always_comb begin
    stageNext = cmdIsLoad &&
                (((xferModeT'(cmdMode) == MODE_STRUCT) && (cmdElems > ELEM_W'(1))) ? 1'b1
                                                                                   : cmdBigEnd);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ   <= '0;
      lenQ    <= '0;
      beatQ   <= '0;
      doubleQ <= 1'b0;
      loadQ   <= 1'b0;
      stageQ  <= 1'b0;
    end else if (strobe.loadCmd) begin
      baseQ   <= cmdBase;
      lenQ    <= listLen;
      beatQ   <= '0;
      doubleQ <= cmdDouble;
      loadQ   <= cmdIsLoad;
      stageQ  <= stageNext;
    end else if (strobe.advance) begin
      beatQ <= beatQ + CNT_W'(1);
    end
  end

  always_comb begin
    pairPos   = {beatQ, 1'b0};
    lenW      = POS_W'(lenQ);
    off0      = doubleQ ? SUM_W'({pairPos, 1'b0}) : SUM_W'(pairPos);
    sum0      = SUM_W'(baseQ) + off0;
    sum1      = sum0 + (doubleQ ? SUM_W'(2) : SUM_W'(1));
    slot0Reg  = sum0[REG_IDX_W-1:0];
    slot1Reg  = sum1[REG_IDX_W-1:0];
    slot0Live = pairPos < lenW;
    slot1Live = (pairPos + POS_W'(1)) < lenW;
    lastBeat  = (pairPos + POS_W'(2)) >= lenW;
    beatIsLoad  = loadQ;
    resultStage = stageQ;
  end

endmodule

// File: rtl/xferSeq.sv
module xferSeq
  import xferSeqPkg::*;
#(
  parameter int REG_IDX_W  = 5,
  parameter int CNT_W      = 5,
  parameter int ELEM_W     = 3,
  parameter int NUM_REGS   = 32,
  parameter int MAX_MULTI  = 16,
  parameter int MAX_STRUCT = 4,
  parameter int MAX_ELEMS  = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startValid,
  input  logic [1:0]           cmdMode,
  input  logic                 cmdIsLoad,
  input  logic [REG_IDX_W-1:0] cmdBase,
  input  logic [CNT_W-1:0]     cmdCount,
  input  logic                 cmdDouble,
  input  logic [1:0]           cmdAlign,
  input  logic [ELEM_W-1:0]    cmdElems,
  input  logic                 cmdBigEnd,
  input  logic                 beatReady,
  output logic                 busy,
  output logic                 done,
  output logic                 cmdError,
  output logic                 beatValid,
  output logic                 beatIsLoad,
  output logic [REG_IDX_W-1:0] slot0Reg,
  output logic                 slot0Valid,
  output logic [REG_IDX_W-1:0] slot1Reg,
  output logic                 slot1Valid,
  output logic                 resultStage
);

  seqStrobeT        strobe;
  logic [CNT_W-1:0] listLen;
  logic             lastBeat, slot0Live, slot1Live, stageRaw;

  xferSeqCtrl #(
    .REG_IDX_W(REG_IDX_W), .CNT_W(CNT_W), .ELEM_W(ELEM_W), .NUM_REGS(NUM_REGS),
    .MAX_MULTI(MAX_MULTI), .MAX_STRUCT(MAX_STRUCT), .MAX_ELEMS(MAX_ELEMS)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .startValid(startValid), .cmdMode(cmdMode),
    .cmdBase(cmdBase), .cmdCount(cmdCount), .cmdDouble(cmdDouble),
    .cmdAlign(cmdAlign), .cmdElems(cmdElems), .beatReady(beatReady),
    .lastBeat(lastBeat), .strobe(strobe), .listLen(listLen), .busy(busy),
    .done(done), .beatValid(beatValid), .cmdError(cmdError)
  );

  xferSeqPath #(
    .REG_IDX_W(REG_IDX_W), .CNT_W(CNT_W), .ELEM_W(ELEM_W)
  ) i_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmdMode(cmdMode),
    .cmdIsLoad(cmdIsLoad), .cmdBase(cmdBase), .listLen(listLen),
    .cmdDouble(cmdDouble), .cmdElems(cmdElems), .cmdBigEnd(cmdBigEnd),
    .slot0Reg(slot0Reg), .slot1Reg(slot1Reg), .slot0Live(slot0Live),
    .slot1Live(slot1Live), .lastBeat(lastBeat), .beatIsLoad(beatIsLoad),
    .resultStage(stageRaw)
  );

  always_comb begin
    slot0Valid  = beatValid && slot0Live;
    slot1Valid  = beatValid && slot1Live;
    resultStage = stageRaw;
  end

endmodule

// File: rtl/xferSeqChecker.sv
module xferSeqChecker #(
  parameter int REG_IDX_W = 5
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 startValid,
  input logic                 beatReady,
  input logic                 busy,
  input logic                 done,
  input logic                 cmdError,
  input logic                 beatValid,
  input logic [REG_IDX_W-1:0] slot0Reg,
  input logic [REG_IDX_W-1:0] slot1Reg,
  input logic                 slot0Valid,
  input logic                 slot1Valid
);

  // R10: completion only on an accepted beat
  a_r10_done_on_accept: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (beatValid && beatReady));

  // R10: sequence ends right after completion
  a_r10_done_ends_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

  // R8: a rejected command never coexists with a running sequence
  a_r8_err_not_busy: assert property (@(posedge clk) disable iff (!rstN)
    cmdError |-> (!busy && !beatValid));

  // R11: stalled beat holds its register numbers
  a_r11_stall_hold: assert property (@(posedge clk) disable iff (!rstN)
    (beatValid && !beatReady) |=> (beatValid && $stable(slot0Reg) && $stable(slot1Reg)));

  // R3: slot 1 is only used alongside slot 0
  a_r3_slot_order: assert property (@(posedge clk) disable iff (!rstN)
    slot1Valid |-> slot0Valid);

  // R9: a running sequence only stops through completion
  a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);

  // R2: busy only starts after a start strobe
  a_r2_busy_after_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(startValid));

endmodule

bind xferSeq xferSeqChecker #(.REG_IDX_W(REG_IDX_W)) i_xferSeqChecker (
  .clk(clk), .rstN(rstN), .startValid(startValid), .beatReady(beatReady),
  .busy(busy), .done(done), .cmdError(cmdError), .beatValid(beatValid),
  .slot0Reg(slot0Reg), .slot1Reg(slot1Reg), .slot0Valid(slot0Valid),
  .slot1Valid(slot1Valid)
);

// File: tb/test_xferSeq.sv
module test_xferSeq;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startValid = 1'b0;
  logic [1:0] cmdMode = '0;
  logic cmdIsLoad = 1'b0;
  logic [4:0] cmdBase = '0;
  logic [4:0] cmdCount = '0;
  logic cmdDouble = 1'b0;
  logic [1:0] cmdAlign = '0;
  logic [2:0] cmdElems = '0;
  logic cmdBigEnd = 1'b0;
  logic beatReady = 1'b1;
  logic busy, done, cmdError, beatValid, beatIsLoad, slot0Valid, slot1Valid, resultStage;
  logic [4:0] slot0Reg, slot1Reg;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  xferSeq i_xferSeq (
    .clk(clk), .rstN(rstN), .startValid(startValid), .cmdMode(cmdMode),
    .cmdIsLoad(cmdIsLoad), .cmdBase(cmdBase), .cmdCount(cmdCount),
    .cmdDouble(cmdDouble), .cmdAlign(cmdAlign), .cmdElems(cmdElems),
    .cmdBigEnd(cmdBigEnd), .beatReady(beatReady), .busy(busy), .done(done),
    .cmdError(cmdError), .beatValid(beatValid), .beatIsLoad(beatIsLoad),
    .slot0Reg(slot0Reg), .slot0Valid(slot0Valid), .slot1Reg(slot1Reg),
    .slot1Valid(slot1Valid), .resultStage(resultStage)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Runs one command and compares against values computed from the requirements
  task automatic runCmd(input int mode, input bit isLoad, input int base, input int cnt,
                        input bit dbl, input int align, input int elems, input bit bigEnd,
                        input bit stall, input bit inject);
    int stride = dbl ? 2 : 1;
    int n = (mode == 0) ? 1 : cnt;
    bit expErr;
    int expBeats = (n + 1) / 2;
    int expCyc;
    int expStage;
    int cyc = 0;
    int beats = 0;
    int stalls = 0;
    int doneCnt = 0;
    int slotBad = 0;
    int stageBad = 0;
    int lastIdx = base + stride * (n - 1);

    case (mode)
      0: expErr = 1'b0;
      1: expErr = (n == 0) || (n > 16) || (lastIdx > 31);
      2: expErr = (n == 0) || (n > 4) || (elems < 1) || (elems > 4) || (lastIdx > 31);
      default: expErr = 1'b1;
    endcase
    if (mode == 2) expCyc = expBeats + ((align >= 2) ? 0 : 1);
    else           expCyc = expBeats + 1;
    expStage = !isLoad ? 0 : ((mode == 2 && elems > 1) ? 1 : int'(bigEnd));

    @(negedge clk);
    cmdMode = 2'(mode); cmdIsLoad = isLoad; cmdBase = 5'(base); cmdCount = 5'(cnt);
    cmdDouble = dbl; cmdAlign = 2'(align); cmdElems = 3'(elems); cmdBigEnd = bigEnd;
    startValid = 1'b1;
    @(negedge clk);
    startValid = 1'b0;
    // R12: scramble the command inputs once captured
    cmdBase = ~cmdBase; cmdCount = ~cmdCount; cmdDouble = ~cmdDouble;
    cmdIsLoad = ~cmdIsLoad; cmdBigEnd = ~cmdBigEnd; cmdElems = ~cmdElems;

    if (expErr) begin
      #1;
      chk(cmdError && !busy && !beatValid, "R8", "reject pulse", int'(cmdError), 1);
      @(negedge clk);
      #1;
      chk(!cmdError && !busy && !beatValid, "R8", "reject is one cycle, no run",
          int'({cmdError, busy, beatValid}), 0);
      return;
    end

    cyc = 1;
    forever begin
      beatReady = !(stall && (cyc % 3 == 2));
      if (inject && cyc == 1) startValid = 1'b1;   // R9: start while busy
      if (inject && cyc == 2) startValid = 1'b0;
      #1;
      if (!busy) break;
      if (beatValid && !beatReady) stalls++;
      if (beatValid && beatReady) begin
        if (slot0Reg != 5'(base + stride * 2 * beats) || !slot0Valid) slotBad++;
        if (slot1Valid != ((2 * beats + 1) < n)) slotBad++;
        if (slot1Valid && slot1Reg != 5'(base + stride * (2 * beats + 1))) slotBad++;
        if (beatIsLoad != isLoad || int'(resultStage) != expStage) stageBad++;
        if (done != (beats == expBeats - 1)) slotBad++;
        beats++;
      end
      if (done) doneCnt++;
      if (cyc > 100) break;
      @(negedge clk);
      cyc++;
    end
    startValid = 1'b0;
    beatReady = 1'b1;
    chk(cmdError == 1'b0, "R8", "no error on valid command", int'(cmdError), 0);
    if (mode == 0)      chk(cyc - 1 == 2 + stalls, "R5", "single cycles", cyc - 1, 2 + stalls);
    else if (mode == 1) chk(cyc - 1 == expCyc + stalls, "R2", "list cycles", cyc - 1, expCyc + stalls);
    else                chk(cyc - 1 == expCyc + stalls, "R6", "struct cycles", cyc - 1, expCyc + stalls);
    chk(beats == expBeats, "R3", "beat count", beats, expBeats);
    chk(slotBad == 0, dbl ? "R4" : "R3", "slot contents", slotBad, 0);
    chk(stageBad == 0, "R7", "result stage", stageBad, 0);
    chk(doneCnt == 1, "R10", "done pulses", doneCnt, 1);
    if (stall)  chk(stalls > 0 || expBeats < 2, "R11", "stalls seen", stalls, 1);
    if (inject) chk(slotBad == 0, "R9", "start while busy ignored", slotBad, 0);
    if (inject) chk(slotBad == 0, "R12", "captured fields used", slotBad, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    chk(!busy && !done && !cmdError && !beatValid, "R1", "reset state",
        int'({busy, done, cmdError, beatValid}), 0);

    // R2 R3 R4 R8: list transfers over length, base and stride
    for (int n = 0; n <= 20; n++)
      for (int b = 0; b < 4; b++)
        for (int d = 0; d < 2; d++)
          runCmd(1, n[0], (b == 0) ? 0 : (b == 1) ? 3 : (b == 2) ? 17 : 31, n,
                 d[0], b, 1, b[0], 1'b0, 1'b0);

    // R6 R7 R8: structure transfers over length, alignment, element count
    for (int n = 0; n <= 5; n++)
      for (int a = 0; a < 4; a++)
        for (int e = 0; e <= 5; e++)
          for (int b = 0; b < 2; b++)
            for (int d = 0; d < 2; d++)
              runCmd(2, 1'b1, b ? 29 : 0, n, d[0], a, e, b[0], 1'b0, 1'b0);

    // R5 R7: single register ignores count, alignment and stride
    for (int b = 0; b < 32; b += 7)
      for (int a = 0; a < 4; a++)
        runCmd(0, a[0], b, (a == 0) ? 0 : 9, a[1], a, 2, b[0], 1'b0, 1'b0);
    runCmd(0, 1'b1, 31, 31, 1'b1, 3, 0, 1'b1, 1'b0, 1'b0);

    // R8: reserved mode
    runCmd(3, 1'b1, 0, 2, 1'b0, 0, 1, 1'b0, 1'b0, 1'b0);

    // R9 R11 R12: stalls and starts during a sequence
    for (int n = 1; n <= 16; n++) begin
      runCmd(1, 1'b1, 0, n, n[0], 0, 1, 1'b0, 1'b1, 1'b0);
      runCmd(1, 1'b0, 2, n, 1'b0, 0, 1, 1'b1, 1'b0, 1'b1);
    end
    runCmd(2, 1'b1, 4, 4, 1'b1, 2, 3, 1'b0, 1'b1, 1'b1);
    runCmd(0, 1'b1, 8, 1, 1'b0, 0, 1, 1'b0, 1'b1, 1'b1);

    repeat (2) @(negedge clk);
    #1;
    chk(!busy && !beatValid, "R10", "idle after all runs", int'({busy, beatValid}), 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule